// File: doc/BRIEF.md
# Vector length setup unit

This block carries out the vector-length setup that a vector group header asks for. It receives the already decoded header fields with a start strobe. It then holds the architectural vector length (VL), the maximum vector length (MAXVL) and a sub-vector length field, and updates them once per command. When the command names a scalar register as the length source, the unit fetches that register through a request/acknowledge read port before it commits.

The block has two modes. In the normal mode the new length is a 5-bit immediate plus one, or the value of a scalar register, and it is clamped to the current MAXVL. In the forced mode a 6-bit immediate plus one sets MAXVL and VL together. In both modes the committed length may also be written back to a scalar destination register. That write is skipped when the destination index is zero.

A single-cycle done pulse marks the cycle in which VL, MAXVL, the sub-vector length and any writeback all become visible together. Between commands the state registers keep their values.

Top module: `vl_setup_unit`

## Requirements
- R1: After reset, `vl` is 1, `maxvl` is MAXVL_LIMIT (64 by default) and `subvl` is 0. `done`, `rd_req` and `wb_en` are all low.
- R2: In normal mode with `vl_from_reg`=0, the new VL is `len_field[4:0]`+1 (0b00000 gives 1), limited to the current MAXVL. No read request is raised. `done` rises in the second cycle after the cycle in which `start` is sampled.
- R3: In normal mode with `vl_from_reg`=1, `rd_req` rises one cycle after `start` with `rd_addr`=`len_field[4:0]`. It stays high with a stable address until `rd_ack`. The new VL is the returned value limited to MAXVL, and a returned zero commits as zero.
- R4: In normal mode MAXVL is left unchanged, and a committed VL never exceeds MAXVL.
- R5: With `force_set`=1, both MAXVL and VL become `len_field`+1 (0b000000 gives 1, 0b111111 gives 64). No register read is made.
- R6: When `vl_dest` is nonzero, `wb_en` pulses in the `done` cycle with `wb_addr`=`vl_dest` and `wb_data` equal to the new VL. When `vl_dest` is zero, no write is issued, but VL is still updated.
- R7: `done` is a one-cycle pulse. The new VL, MAXVL and sub-vector length appear in that same cycle and not earlier.
- R8: VL, MAXVL and the sub-vector length hold their values between commands. A `start` raised while a command is in progress is ignored.
- R9: The sub-vector length field `subvl_in` is captured at `start` and copied unchanged to `subvl` at commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command; fields are sampled with it |
| force_set | input | 1 | 1 selects the forced mode (MAXVL and VL from the 6-bit immediate) |
| vl_from_reg | input | 1 | In normal mode, 1 takes the length from a scalar register |
| len_field | input | 6 | Immediate, or register index in `[4:0]` |
| vl_dest | input | 5 | Scalar destination register index; 0 suppresses writeback |
| subvl_in | input | 2 | Sub-vector length field, passed through |
| rd_req | output | 1 | Register read request |
| rd_addr | output | 5 | Register read index |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 64 | Read response value |
| vl | output | 7 | Architectural vector length |
| maxvl | output | 7 | Architectural maximum vector length |
| subvl | output | 2 | Architectural sub-vector length field |
| wb_en | output | 1 | Scalar register write strobe |
| wb_addr | output | 5 | Scalar register write index |
| wb_data | output | 64 | Scalar register write value |
| done | output | 1 | Command complete pulse |

## Verification
The read-port properties assume that `rd_ack` arrives only while `rd_req` is high, and only once per request. The stimulus raises the acknowledge for exactly one cycle, after a chosen delay, and only once the request has been seen. The assertions also take `start` to be a short pulse. The stimulus drops `start` after one cycle, except for deliberate pulses raised while a register fetch is pending, which the unit must ignore. Random commands mix the two modes, both length sources, zero and nonzero destinations, and register values from zero up to full 64-bit magnitudes, so that clamping occurs often.

// File: rtl/vl_setup_pkg.sv
package vl_setup_pkg;

  // Field widths of the decoded header
  localparam int unsigned VLS_FIELD_W = 6;
  localparam int unsigned VLS_AW      = 5;
  localparam int unsigned VLS_SUBVL_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FETCH,
    PH_COMMIT
  } vls_phase_e;

  typedef struct packed {
    logic                   force_set;
    logic                   from_reg;
    logic [VLS_FIELD_W-1:0] len_field;
    logic [VLS_AW-1:0]      dest;
    logic [VLS_SUBVL_W-1:0] subvl;
  } vls_cmd_t;

endpackage

// File: rtl/vl_src_fetch.sv
module vl_src_fetch #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic [AW-1:0]   src_idx,
  input  logic            rd_ack,
  input  logic [XLEN-1:0] rd_data,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  output logic            got,
  output logic [XLEN-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      got     <= 1'b0;
      value   <= '0;
    end else begin
      got <= 1'b0;
      if (launch) begin
        rd_req  <= 1'b1;
        rd_addr <= src_idx;
      end else if (rd_req && rd_ack) begin
        rd_req <= 1'b0;
        got    <= 1'b1;
        value  <= rd_data;
      end
    end
  end

endmodule

// File: rtl/vl_len_calc.sv
module vl_len_calc #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned VLW     = 7,
  parameter int unsigned FIELD_W = 6
) (
  input  logic               force_set,
  input  logic               from_reg,
  input  logic [FIELD_W-1:0] len_field,
  input  logic [XLEN-1:0]    reg_value,
  input  logic [VLW-1:0]     maxvl_cur,
  output logic [VLW-1:0]     next_vl,
  output logic [VLW-1:0]     next_maxvl
);

  localparam int unsigned PADW = XLEN - VLW;

  logic [VLW-1:0]  imm_short;
  logic [VLW-1:0]  imm_long;
  logic [XLEN-1:0] candidate;
  logic [XLEN-1:0] cap;

  always_comb begin
    imm_short = {{(VLW-FIELD_W+1){1'b0}}, len_field[FIELD_W-2:0]} + {{(VLW-1){1'b0}}, 1'b1};
    imm_long  = {{(VLW-FIELD_W){1'b0}}, len_field} + {{(VLW-1){1'b0}}, 1'b1};
    cap       = {{PADW{1'b0}}, maxvl_cur};
    candidate = from_reg ? reg_value : {{PADW{1'b0}}, imm_short};
    if (force_set) begin
      next_vl    = imm_long;
      next_maxvl = imm_long;
    end else begin
      next_maxvl = maxvl_cur;
      if (candidate > cap) next_vl = maxvl_cur;
      else                 next_vl = candidate[VLW-1:0];
    end
  end

endmodule

// File: rtl/vl_arch_state.sv
module vl_arch_state #(
  parameter int unsigned XLEN        = 64,
  parameter int unsigned VLW         = 7,
  parameter int unsigned AW          = 5,
  parameter int unsigned SW          = 2,
  parameter int unsigned RESET_VL    = 1,
  parameter int unsigned RESET_MAXVL = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic [VLW-1:0]  next_vl,
  input  logic [VLW-1:0]  next_maxvl,
  input  logic [SW-1:0]   next_subvl,
  input  logic [AW-1:0]   dest,
  output logic [VLW-1:0]  vl,
  output logic [VLW-1:0]  maxvl,
  output logic [SW-1:0]   subvl,
  output logic            done,
  output logic            wb_en,
  output logic [AW-1:0]   wb_addr,
  output logic [XLEN-1:0] wb_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vl      <= VLW'(RESET_VL);
      maxvl   <= VLW'(RESET_MAXVL);
      subvl   <= '0;
      done    <= 1'b0;
      wb_en   <= 1'b0;
      wb_addr <= '0;
      wb_data <= '0;
    end else begin
      done  <= commit;
      wb_en <= commit && (dest != '0);
      if (commit) begin
        vl      <= next_vl;
        maxvl   <= next_maxvl;
        subvl   <= next_subvl;
        wb_addr <= dest;
        wb_data <= {{(XLEN-VLW){1'b0}}, next_vl};
      end
    end
  end

endmodule

// File: rtl/vl_setup_unit.sv
module vl_setup_unit
  import vl_setup_pkg::*;
#(
  parameter int unsigned XLEN        = 64,
  parameter int unsigned MAXVL_LIMIT = 64,
  parameter int unsigned RESET_VL    = 1,
  parameter int unsigned VLW         = $clog2(MAXVL_LIMIT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   force_set,
  input  logic                   vl_from_reg,
  input  logic [VLS_FIELD_W-1:0] len_field,
  input  logic [VLS_AW-1:0]      vl_dest,
  input  logic [VLS_SUBVL_W-1:0] subvl_in,
  output logic                   rd_req,
  output logic [VLS_AW-1:0]      rd_addr,
  input  logic                   rd_ack,
  input  logic [XLEN-1:0]        rd_data,
  output logic [VLW-1:0]         vl,
  output logic [VLW-1:0]         maxvl,
  output logic [VLS_SUBVL_W-1:0] subvl,
  output logic                   wb_en,
  output logic [VLS_AW-1:0]      wb_addr,
  output logic [XLEN-1:0]        wb_data,
  output logic                   done
);

  vls_phase_e      phase;
  vls_cmd_t        cmd_q;
  logic            launch;
  logic            commit;
  logic            got;
  logic [XLEN-1:0] fetched;
  logic [VLW-1:0]  next_vl;
  logic [VLW-1:0]  next_maxvl;

  assign launch = (phase == PH_IDLE) && start && !force_set && vl_from_reg;
  assign commit = (phase == PH_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cmd_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          cmd_q <= '{force_set: force_set, from_reg: vl_from_reg,
                     len_field: len_field, dest: vl_dest, subvl: subvl_in};
          phase <= (!force_set && vl_from_reg) ? PH_FETCH : PH_COMMIT;
        end
        PH_FETCH:  if (got) phase <= PH_COMMIT;
        PH_COMMIT: phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  vl_src_fetch #(.XLEN(XLEN), .AW(VLS_AW)) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .src_idx (len_field[VLS_AW-1:0]),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .got     (got),
    .value   (fetched)
  );

  vl_len_calc #(.XLEN(XLEN), .VLW(VLW), .FIELD_W(VLS_FIELD_W)) u_calc (
    .force_set  (cmd_q.force_set),
    .from_reg   (cmd_q.from_reg),
    .len_field  (cmd_q.len_field),
    .reg_value  (fetched),
    .maxvl_cur  (maxvl),
    .next_vl    (next_vl),
    .next_maxvl (next_maxvl)
  );

  vl_arch_state #(
    .XLEN(XLEN), .VLW(VLW), .AW(VLS_AW), .SW(VLS_SUBVL_W),
    .RESET_VL(RESET_VL), .RESET_MAXVL(MAXVL_LIMIT)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .next_vl    (next_vl),
    .next_maxvl (next_maxvl),
    .next_subvl (cmd_q.subvl),
    .dest       (cmd_q.dest),
    .vl         (vl),
    .maxvl      (maxvl),
    .subvl      (subvl),
    .done       (done),
    .wb_en      (wb_en),
    .wb_addr    (wb_addr),
    .wb_data    (wb_data)
  );

endmodule

// File: rtl/vl_setup_chk.sv
module vl_setup_chk #(
  parameter int unsigned VLW = 7,
  parameter int unsigned AW  = 5,
  parameter int unsigned SW  = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_req,
  input logic           rd_ack,
  input logic [AW-1:0]  rd_addr,
  input logic [VLW-1:0] vl,
  input logic [VLW-1:0] maxvl,
  input logic [SW-1:0]  subvl,
  input logic           wb_en,
  input logic [AW-1:0]  wb_addr,
  input logic           done
);

  AST_VL_WITHIN_MAXVL: assert property (@(posedge clk) disable iff (rst)
    vl <= maxvl);                                                        // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                     // R7

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);                                                     // R6

  AST_WB_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_addr != '0));                                          // R6

  AST_STATE_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(vl) && $stable(maxvl) && $stable(subvl)));        // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));               // R3

  AST_NO_DONE_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !done);                                                   // R7

endmodule

bind vl_setup_unit vl_setup_chk #(
  .VLW(VLW), .AW(vl_setup_pkg::VLS_AW), .SW(vl_setup_pkg::VLS_SUBVL_W)
) u_vl_setup_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_req  (rd_req),
  .rd_ack  (rd_ack),
  .rd_addr (rd_addr),
  .vl      (vl),
  .maxvl   (maxvl),
  .subvl   (subvl),
  .wb_en   (wb_en),
  .wb_addr (wb_addr),
  .done    (done)
);

// File: tb/test_vl_setup_unit.sv
`timescale 1ns/1ps
module test_vl_setup_unit;

  localparam int unsigned XLEN = 64;
  localparam int unsigned MAXL = 64;
  localparam int unsigned VLW  = 7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            force_set = 1'b0;
  logic            vl_from_reg = 1'b0;
  logic [5:0]      len_field = '0;
  logic [4:0]      vl_dest = '0;
  logic [1:0]      subvl_in = '0;
  logic            rd_req;
  logic [4:0]      rd_addr;
  logic            rd_ack = 1'b0;
  logic [XLEN-1:0] rd_data = '0;
  logic [VLW-1:0]  vl;
  logic [VLW-1:0]  maxvl;
  logic [1:0]      subvl;
  logic            wb_en;
  logic [4:0]      wb_addr;
  logic [XLEN-1:0] wb_data;
  logic            done;

  int n_tests = 0;
  int n_fail  = 0;

  longint unsigned m_vl;
  longint unsigned m_maxvl;
  longint unsigned m_subvl;

  always #2.5 clk = ~clk;

  vl_setup_unit #(.XLEN(XLEN), .MAXVL_LIMIT(MAXL)) i_vl_setup_unit (
    .clk(clk), .rst(rst), .start(start), .force_set(force_set),
    .vl_from_reg(vl_from_reg), .len_field(len_field), .vl_dest(vl_dest),
    .subvl_in(subvl_in), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .vl(vl), .maxvl(maxvl), .subvl(subvl), .wb_en(wb_en),
    .wb_addr(wb_addr), .wb_data(wb_data), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned exp_len(input bit f, input bit r,
      input logic [5:0] fld, input longint unsigned rv, input longint unsigned cur_max);
    longint unsigned cand;
    if (f) return longint'(fld) + 1;
    cand = r ? rv : longint'(fld[4:0]) + 1;
    return (cand > cur_max) ? cur_max : cand;
  endfunction

  task automatic run_op(input bit f, input bit r, input logic [5:0] fld,
                        input logic [4:0] d, input logic [1:0] sv,
                        input longint unsigned rv, input int delay, input bit poke);
    longint unsigned e;
    int waited;
    e = exp_len(f, r, fld, rv, m_maxvl);
    if (f) m_maxvl = e;
    m_vl    = e;
    m_subvl = sv;
    @(negedge clk);
    start = 1'b1; force_set = f; vl_from_reg = r;
    len_field = fld; vl_dest = d; subvl_in = sv;
    @(negedge clk);
    start = 1'b0;
    len_field = 6'(~fld); vl_dest = 5'(~d); subvl_in = 2'(~sv); force_set = ~f;
    if (r && !f) begin
      chk("R3", "rd_req raised", rd_req, 1);
      chk("R3", "rd_addr", rd_addr, fld[4:0]);
      for (int i = 0; i < delay; i++) begin
        if (poke && i == 0) begin
          start = 1'b1; force_set = 1'b1; len_field = 6'd2;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
        chk("R3", "rd_req held", rd_req, 1);
        chk("R7", "no early done", done, 0);
      end
      start = 1'b0;
      rd_ack = 1'b1; rd_data = rv;
      @(negedge clk);
      rd_ack = 1'b0; rd_data = {$urandom, $urandom};
      waited = 0;
      while (!done && waited < 20) begin
        @(negedge clk);
        waited++;
      end
      chk("R7", "done after fetch", done, 1);
    end else begin
      chk("R2", "no read request", rd_req, 0);
      chk("R7", "done not yet", done, 0);
      @(negedge clk);
      chk("R2", "done latency", done, 1);
    end
    chk(f ? "R5" : "R4", "vl", vl, m_vl);
    chk(f ? "R5" : "R4", "maxvl", maxvl, m_maxvl);
    chk("R9", "subvl", subvl, m_subvl);
    chk("R6", "wb_en", wb_en, (d != 0));
    if (d != 0) begin
      chk("R6", "wb_addr", wb_addr, d);
      chk("R6", "wb_data", wb_data, m_vl);
    end
    @(negedge clk);
    chk("R7", "done pulse ends", done, 0);
    chk("R6", "wb_en ends", wb_en, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20190621));
    m_vl = 1; m_maxvl = MAXL; m_subvl = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "vl", vl, 1);
    chk("R1", "maxvl", maxvl, MAXL);
    chk("R1", "subvl", subvl, 0);
    chk("R1", "done", done, 0);
    chk("R1", "rd_req", rd_req, 0);
    chk("R1", "wb_en", wb_en, 0);

    run_op(0, 0, 6'd0,  5'd3, 2'd1, 0, 0, 0);     // R2 minimum immediate
    run_op(0, 0, 6'd31, 5'd0, 2'd2, 0, 0, 0);     // R2, R6 no writeback
    chk("R6", "vl updated without writeback", vl, 32);
    run_op(1, 0, 6'd7,  5'd9, 2'd0, 0, 0, 0);     // R5 force to 8
    run_op(0, 0, 6'd31, 5'd4, 2'd3, 0, 0, 0);     // R4 clamp to 8
    run_op(0, 1, 6'd5,  5'd6, 2'd1, 0, 2, 0);     // R3 zero stays zero
    run_op(0, 1, 6'd17, 5'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 3, 1); // R8 ignored start, R4 clamp
    run_op(1, 0, 6'd63, 5'd2, 2'd0, 0, 0, 0);     // R5 force to 64
    run_op(0, 1, 6'd31, 5'd31, 2'd3, 40, 4, 1);   // R3 register value
    repeat (3) @(negedge clk);
    chk("R8", "vl held while idle", vl, m_vl);
    chk("R8", "maxvl held while idle", maxvl, m_maxvl);

    for (int k = 0; k < 200; k++) begin
      bit f;
      bit r;
      longint unsigned rv;
      int sel;
      f = ($urandom % 4) == 0;
      r = $urandom % 2;
      sel = $urandom % 4;
      rv = (sel == 0) ? 0 : (sel == 1) ? longint'($urandom % 80)
         : (sel == 2) ? longint'($urandom % 8) : {$urandom, $urandom};
      run_op(f, r, 6'($urandom), ($urandom % 3 == 0) ? 5'd0 : 5'($urandom),
             2'($urandom), rv, $urandom % 4, $urandom % 2);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule